// File: doc/BRIEF.md
# Bus-Master Error Status Tracker

This block keeps the error record for the master side of a PCI interface. The master state machine sends it one-cycle pulses when a target abort is received, when a master abort occurs, or when a data parity error is reported. A DMA command path sends it a pulse when synchronization is lost. The block also flags an internal failure by itself when a master request is raised while the interface is disabled. Each condition sets a sticky flag. A summary bit gathers all of them and drives a level interrupt.

Two agents clear the record. The host writes ones to configuration-space status bits. The local processor uses two control bits: one clears the error status bits, and a global-reset bit clears the whole record synchronously. Protocol flags give way to a write of one. The internal-failure flag ignores such writes and clears only on a global reset or on the asynchronous active-low bus reset. On the first error after the summary bit was clear, the block records the direction of the failing transaction and its address. The address goes into a read register or a write register according to that direction. The block also turns a control bit into the read command code that the master issues.

Top module: `pci_mst_err_tracker`

## Requirements
- R1: While bus_rst_n is low, and without waiting for a clock edge, cfg_status, sys_bus_status, err_dir_read, err_rd_addr, err_wr_addr and irq_bus_err are all zero and rd_cmd is 4'b0110.
- R2: A pulse on ev_target_abort, ev_master_abort or ev_parity_err sets cfg_status bit 0, 1 or 2 respectively. The same pulse sets cfg_status bit 4 (summary) and sys_bus_status bit 1. All of these are visible after the next clock edge and stay set after the pulse ends.
- R3: A pulse on ev_sync_loss, or mst_req high while if_enable is low, is an internal failure. It sets cfg_status bit 3, cfg_status bit 4 and sys_bus_status bit 0. mst_req with if_enable high sets nothing.
- R4: A cycle with cfg_w1c_we high clears each of cfg_status bits 0, 1, 2 and 4 whose cfg_w1c_data bit is one. It leaves the other bits unchanged. cfg_status bit 3 and sys_bus_status are not affected by this write.
- R5: cfg_status bit 3 and sys_bus_status bit 0 clear only on a clock edge with ctl_global_reset high, or on bus_rst_n low. A clock edge with ctl_global_reset high clears every status bit, both address registers and err_dir_read.
- R6: A clock edge with ctl_err_clear high clears cfg_status bits 0, 1, 2 and 4 and sys_bus_status bit 1. It keeps cfg_status bit 3, sys_bus_status bit 0 and the capture registers.
- R7: irq_bus_err is high exactly when cfg_status bit 4 is high.
- R8: When an event and a clear of the same bit arrive in the same cycle, the bit ends high. The clear here is a write of one or ctl_err_clear.
- R9: An error event that arrives while cfg_status bit 4 is low loads err_dir_read from xfer_is_read (1 = read). It loads xfer_addr into err_rd_addr for a read, or into err_wr_addr for a write. The other address register is left unchanged.
- R10: Error events that arrive while cfg_status bit 4 is high leave err_dir_read, err_rd_addr and err_wr_addr unchanged. After bit 4 has been cleared, the next error captures again.
- R11: One clock edge after ctl_read_multi is sampled, rd_cmd is 4'b1100 (read multiple) if it was high and 4'b0110 (plain memory read) if it was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_rst_n | input | 1 | Asynchronous active-low bus reset |
| ev_target_abort | input | 1 | Target abort received, one-cycle pulse |
| ev_master_abort | input | 1 | Master abort, one-cycle pulse |
| ev_parity_err | input | 1 | Data parity error reported, one-cycle pulse |
| ev_sync_loss | input | 1 | Lost sync with the DMA command source, pulse |
| mst_req | input | 1 | Master transaction attempt |
| if_enable | input | 1 | Master interface enabled |
| xfer_is_read | input | 1 | Current transaction is a read |
| xfer_addr | input | AW | Current transaction address |
| cfg_w1c_we | input | 1 | Host write strobe for the status bits |
| cfg_w1c_data | input | 5 | Host write data, one per status bit |
| ctl_global_reset | input | 1 | Local synchronous clear of the whole record |
| ctl_err_clear | input | 1 | Local clear of the error status bits |
| ctl_read_multi | input | 1 | Select the read-multiple command |
| cfg_status | output | 5 | {summary, internal fail, parity, master abort, target abort} |
| sys_bus_status | output | 2 | Bit 1 protocol error, bit 0 internal failure |
| err_dir_read | output | 1 | Direction of the captured error, 1 = read |
| err_rd_addr | output | AW | Captured failing read address |
| err_wr_addr | output | AW | Captured failing write address |
| irq_bus_err | output | 1 | Level bus-error interrupt |
| rd_cmd | output | 4 | Bus command code for reads |

## Verification
The hardest states to reach are the ones where a set and a clear meet in one cycle, and the one where a second error arrives while the first capture is still held. The bench drives an abort pulse in the same cycle as a write of one to that bit, and an event together with ctl_err_clear. It then raises an error of the opposite direction at a new address while the summary bit is set. It clears the summary bit and raises a third error to show that capture is armed again. The internal-failure flag is checked while a write of all ones is applied, so the test shows it survives that write.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int CFG_W = 5;
  localparam int B_TA  = 0;
  localparam int B_MA  = 1;
  localparam int B_DP  = 2;
  localparam int B_IF  = 3;
  localparam int B_ME  = 4;
  localparam int NPROT = 3;
  localparam logic [3:0] CMD_MEM_RD    = 4'b0110;
  localparam logic [3:0] CMD_MEM_RD_ML = 4'b1100;
endpackage

// File: rtl/pme_sticky_bit.sv
module pme_sticky_bit #(
  parameter bit HOST_CLR = 1'b1,
  parameter bit SOFT_CLR = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sync_clr,
  input  logic set,
  input  logic w1c,
  input  logic soft_clr,
  output logic q
);
  logic clr_req;
  assign clr_req = (HOST_CLR && w1c) || (SOFT_CLR && soft_clr);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       q <= 1'b0;
    else if (sync_clr) q <= 1'b0;
    else if (set)      q <= 1'b1;
    else if (clr_req)  q <= 1'b0;
  end
endmodule

// File: rtl/pme_capture.sv
module pme_capture #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          sync_clr,
  input  logic          armed,
  input  logic          ev_any,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  output logic          dir_read,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr
);
  logic load;
  assign load = armed && ev_any;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      dir_read <= 1'b0;
      rd_addr  <= '0;
      wr_addr  <= '0;
    end else if (sync_clr) begin
      dir_read <= 1'b0;
      rd_addr  <= '0;
      wr_addr  <= '0;
    end else if (load) begin
      dir_read <= is_read;
      if (is_read) rd_addr <= addr;
      else         wr_addr <= addr;
    end
  end
endmodule

// File: rtl/pme_cmd_sel.sv
module pme_cmd_sel
  import pme_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       multi,
  output logic [3:0] cmd
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cmd <= CMD_MEM_RD;
    else         cmd <= multi ? CMD_MEM_RD_ML : CMD_MEM_RD;
  end
endmodule

// File: rtl/pci_mst_err_tracker.sv
module pci_mst_err_tracker
  import pme_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             bus_rst_n,
  input  logic             ev_target_abort,
  input  logic             ev_master_abort,
  input  logic             ev_parity_err,
  input  logic             ev_sync_loss,
  input  logic             mst_req,
  input  logic             if_enable,
  input  logic             xfer_is_read,
  input  logic [AW-1:0]    xfer_addr,
  input  logic             cfg_w1c_we,
  input  logic [CFG_W-1:0] cfg_w1c_data,
  input  logic             ctl_global_reset,
  input  logic             ctl_err_clear,
  input  logic             ctl_read_multi,
  output logic [CFG_W-1:0] cfg_status,
  output logic [1:0]       sys_bus_status,
  output logic             err_dir_read,
  output logic [AW-1:0]    err_rd_addr,
  output logic [AW-1:0]    err_wr_addr,
  output logic             irq_bus_err,
  output logic [3:0]       rd_cmd
);
  logic [NPROT-1:0] prot_ev;
  logic [CFG_W-1:0] host_clr;
  logic             int_fail_ev;
  logic             any_prot_ev;
  logic             any_ev;

  assign prot_ev     = {ev_parity_err, ev_master_abort, ev_target_abort};
  assign int_fail_ev = ev_sync_loss || (mst_req && !if_enable);
  assign any_prot_ev = |prot_ev;
  assign any_ev      = any_prot_ev || int_fail_ev;
  assign host_clr    = cfg_w1c_we ? cfg_w1c_data : '0;

  // protocol flags: host write-one and local clear both apply
  for (genvar i = 0; i < NPROT; i++) begin : g_prot
    pme_sticky_bit #(.HOST_CLR(1'b1), .SOFT_CLR(1'b1)) u_flag (
      .clk(clk), .arst_n(bus_rst_n), .sync_clr(ctl_global_reset),
      .set(prot_ev[i]), .w1c(host_clr[i]), .soft_clr(ctl_err_clear),
      .q(cfg_status[i])
    );
  end

  // internal failure: immune to both soft clears
  pme_sticky_bit #(.HOST_CLR(1'b0), .SOFT_CLR(1'b0)) u_int_fail (
    .clk(clk), .arst_n(bus_rst_n), .sync_clr(ctl_global_reset),
    .set(int_fail_ev), .w1c(host_clr[B_IF]), .soft_clr(ctl_err_clear),
    .q(cfg_status[B_IF])
  );

  pme_sticky_bit #(.HOST_CLR(1'b1), .SOFT_CLR(1'b1)) u_summary (
    .clk(clk), .arst_n(bus_rst_n), .sync_clr(ctl_global_reset),
    .set(any_ev), .w1c(host_clr[B_ME]), .soft_clr(ctl_err_clear),
    .q(cfg_status[B_ME])
  );

  // local status register: host writes do not reach it
  pme_sticky_bit #(.HOST_CLR(1'b0), .SOFT_CLR(1'b1)) u_sys_prot (
    .clk(clk), .arst_n(bus_rst_n), .sync_clr(ctl_global_reset),
    .set(any_prot_ev), .w1c(1'b0), .soft_clr(ctl_err_clear),
    .q(sys_bus_status[1])
  );

  pme_sticky_bit #(.HOST_CLR(1'b0), .SOFT_CLR(1'b0)) u_sys_int (
    .clk(clk), .arst_n(bus_rst_n), .sync_clr(ctl_global_reset),
    .set(int_fail_ev), .w1c(1'b0), .soft_clr(ctl_err_clear),
    .q(sys_bus_status[0])
  );

  pme_capture #(.AW(AW)) u_capture (
    .clk(clk), .arst_n(bus_rst_n), .sync_clr(ctl_global_reset),
    .armed(!cfg_status[B_ME]), .ev_any(any_ev),
    .is_read(xfer_is_read), .addr(xfer_addr),
    .dir_read(err_dir_read), .rd_addr(err_rd_addr), .wr_addr(err_wr_addr)
  );

  pme_cmd_sel u_cmd (
    .clk(clk), .arst_n(bus_rst_n), .multi(ctl_read_multi), .cmd(rd_cmd)
  );

  assign irq_bus_err = cfg_status[B_ME];
endmodule

// File: rtl/pme_err_checker.sv
module pme_err_checker
  import pme_pkg::*;
#(
  parameter int AW = 32
) (
  input logic             clk,
  input logic             bus_rst_n,
  input logic             ev_target_abort,
  input logic             ev_master_abort,
  input logic             ev_parity_err,
  input logic             ev_sync_loss,
  input logic             mst_req,
  input logic             if_enable,
  input logic             xfer_is_read,
  input logic [AW-1:0]    xfer_addr,
  input logic             cfg_w1c_we,
  input logic [CFG_W-1:0] cfg_w1c_data,
  input logic             ctl_global_reset,
  input logic             ctl_err_clear,
  input logic             ctl_read_multi,
  input logic [CFG_W-1:0] cfg_status,
  input logic [1:0]       sys_bus_status,
  input logic             err_dir_read,
  input logic [AW-1:0]    err_rd_addr,
  input logic [AW-1:0]    err_wr_addr,
  input logic             irq_bus_err,
  input logic [3:0]       rd_cmd
);
  a_r3_int_fail_sets: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (ev_sync_loss && !ctl_global_reset) |=>
      (cfg_status[B_IF] && cfg_status[B_ME] && sys_bus_status[0]));

  a_r5_int_fail_survives_w1c: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (cfg_status[B_IF] && !ctl_global_reset) |=> cfg_status[B_IF]);

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (ev_master_abort && !ctl_global_reset) |=> (cfg_status[B_MA] && irq_bus_err));

  a_r10_capture_held: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (irq_bus_err && !ctl_global_reset) |=>
      ($stable(err_rd_addr) && $stable(err_wr_addr) && $stable(err_dir_read)));

  a_r11_read_cmd: assert property (@(posedge clk) disable iff (!bus_rst_n)
    ctl_read_multi |=> (rd_cmd == CMD_MEM_RD_ML));

  a_r6_soft_clear: assert property (@(posedge clk) disable iff (!bus_rst_n)
    (ctl_err_clear && !ev_target_abort && !ev_master_abort && !ev_parity_err
     && !ev_sync_loss && !mst_req) |=> (!irq_bus_err && !sys_bus_status[1]));
endmodule

bind pci_mst_err_tracker pme_err_checker #(.AW(AW)) u_err_chk (.*);

// File: tb/tb_pci_mst_err_tracker.sv
`timescale 1ns/1ps
module tb_pci_mst_err_tracker;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          bus_rst_n = 1'b0;
  logic          ev_target_abort = 0, ev_master_abort = 0, ev_parity_err = 0;
  logic          ev_sync_loss = 0, mst_req = 0, if_enable = 1;
  logic          xfer_is_read = 0;
  logic [AW-1:0] xfer_addr = '0;
  logic          cfg_w1c_we = 0;
  logic [4:0]    cfg_w1c_data = '0;
  logic          ctl_global_reset = 0, ctl_err_clear = 0, ctl_read_multi = 0;
  logic [4:0]    cfg_status;
  logic [1:0]    sys_bus_status;
  logic          err_dir_read, irq_bus_err;
  logic [AW-1:0] err_rd_addr, err_wr_addr;
  logic [3:0]    rd_cmd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_mst_err_tracker #(.AW(AW)) dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_reset();
    @(negedge clk);
    bus_rst_n = 1'b0;
    #1;
    tick();
    bus_rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse_ev(input int which, input logic rd, input logic [AW-1:0] a);
    xfer_is_read = rd;
    xfer_addr = a;
    case (which)
      0: ev_target_abort = 1;
      1: ev_master_abort = 1;
      2: ev_parity_err = 1;
      default: ev_sync_loss = 1;
    endcase
    tick();
    {ev_target_abort, ev_master_abort, ev_parity_err, ev_sync_loss} = '0;
  endtask

  task automatic host_w1c(input logic [4:0] d);
    cfg_w1c_we = 1; cfg_w1c_data = d;
    tick();
    cfg_w1c_we = 0; cfg_w1c_data = '0;
  endtask

  task automatic t_reset_state();
    // put state in, then assert bus reset and look before any clock edge
    pulse_ev(1, 1'b1, 32'h1234_0000);
    tick();
    bus_rst_n = 1'b0;
    #0.5;
    check("R1 status async", {57'd0, cfg_status, sys_bus_status}, 64'd0);
    check("R1 capture async", {err_dir_read, err_rd_addr, err_wr_addr}, 64'd0);
    check("R1 irq/cmd", {irq_bus_err, rd_cmd}, {59'd0, 1'b0, 4'b0110});
    tick();
    bus_rst_n = 1'b1;
    tick();
  endtask

  task automatic t_protocol();
    for (int i = 0; i < 3; i++) begin
      bus_reset();
      pulse_ev(i, 1'b0, 32'h10 + i);
      tick();
      check("R2 flag set held", cfg_status, 5'b10000 | (5'd1 << i));
      check("R2 sys bit1", sys_bus_status, 2'b10);
      check("R7 irq follows summary", irq_bus_err, 1'b1);
    end
  endtask

  task automatic t_internal();
    bus_reset();
    pulse_ev(3, 1'b0, 32'h20);
    check("R3 sync loss", {cfg_status, sys_bus_status}, {5'b11000, 2'b01});
    bus_reset();
    if_enable = 1; mst_req = 1; tick(); mst_req = 0;
    check("R3 enabled req no error", {cfg_status, sys_bus_status}, 7'd0);
    if_enable = 0; mst_req = 1; tick(); mst_req = 0; if_enable = 1;
    check("R3 disabled req", {cfg_status, sys_bus_status}, {5'b11000, 2'b01});
  endtask

  task automatic t_w1c();
    bus_reset();
    pulse_ev(0, 1'b0, 0);
    pulse_ev(2, 1'b0, 0);
    host_w1c(5'b00001);
    check("R4 selective w1c", cfg_status, 5'b10100);
    pulse_ev(3, 1'b0, 0);
    host_w1c(5'b11111);
    check("R4 int fail immune", cfg_status, 5'b01000);
    check("R4 sys untouched", sys_bus_status, 2'b11);
    check("R7 irq low with only int fail", irq_bus_err, 1'b0);
  endtask

  task automatic t_soft_and_global();
    bus_reset();
    pulse_ev(1, 1'b1, 32'hAAAA_0001);
    pulse_ev(3, 1'b0, 32'h5);
    ctl_err_clear = 1; tick(); ctl_err_clear = 0;
    check("R6 err clear", {cfg_status, sys_bus_status}, {5'b01000, 2'b01});
    check("R6 capture kept", err_rd_addr, 32'hAAAA_0001);
    ctl_global_reset = 1; tick(); ctl_global_reset = 0;
    check("R5 global reset status", {cfg_status, sys_bus_status}, 7'd0);
    check("R5 global reset capture", {err_dir_read, err_rd_addr, err_wr_addr}, 64'd0);
  endtask

  task automatic t_set_wins();
    bus_reset();
    pulse_ev(1, 1'b0, 0);
    ev_master_abort = 1; cfg_w1c_we = 1; cfg_w1c_data = 5'b10010;
    tick();
    ev_master_abort = 0; cfg_w1c_we = 0; cfg_w1c_data = '0;
    check("R8 set beats w1c", cfg_status, 5'b10010);
    ev_parity_err = 1; ctl_err_clear = 1;
    tick();
    ev_parity_err = 0; ctl_err_clear = 0;
    check("R8 set beats soft clear", cfg_status[2], 1'b1);
  endtask

  task automatic t_capture();
    bus_reset();
    pulse_ev(0, 1'b1, 32'hCAFE_0100);
    check("R9 read dir", err_dir_read, 1'b1);
    check("R9 read addr", err_rd_addr, 32'hCAFE_0100);
    check("R9 write addr untouched", err_wr_addr, 32'd0);
    pulse_ev(1, 1'b0, 32'hBEEF_0200);
    check("R10 held dir", err_dir_read, 1'b1);
    check("R10 held addrs", {err_rd_addr, err_wr_addr}, {32'hCAFE_0100, 32'd0});
    host_w1c(5'b10000);
    pulse_ev(2, 1'b0, 32'hBEEF_0300);
    check("R10 rearmed dir", err_dir_read, 1'b0);
    check("R9 write addr", {err_rd_addr, err_wr_addr}, {32'hCAFE_0100, 32'hBEEF_0300});
  endtask

  task automatic t_read_cmd();
    ctl_read_multi = 1; tick();
    check("R11 multiple", rd_cmd, 4'b1100);
    ctl_read_multi = 0; tick();
    check("R11 plain", rd_cmd, 4'b0110);
  endtask

  initial begin
    tick(); tick();
    bus_rst_n = 1'b1;
    tick();
    t_reset_state();
    t_protocol();
    t_internal();
    t_w1c();
    t_soft_and_global();
    t_set_wins();
    t_capture();
    t_read_cmd();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule